// File: doc/BRIEF.md
# Store Buffer With Independent Address and Data Readiness

This block holds pending stores for an out-of-order load/store unit. When a store is issued, one free slot takes three things: the base register, given either as a value or as the tag of the unit still computing it; a signed immediate offset; and the value to store, also given either as a value or as a tag. Each slot listens to the shared result broadcast bus. It captures a missing base or a missing data word when the tag on the bus matches the tag it is waiting for. Address readiness and data readiness are tracked separately, so the two can complete in either order.

Once a slot's base is known, the slot forms the effective address on the next clock edge. Writes leave through a valid/ready memory port in strict allocation order. Only the oldest slot may present a write, and a younger store waits behind it even when it is fully ready. The slot frees on the edge where memory accepts the write. A store never drives the broadcast bus.

Back-pressure works through two handshakes. On the allocation side, `alloc_ready` falls while every slot is occupied, and the issue stage must hold its request. On the memory side, the block keeps `mem_valid`, `mem_addr` and `mem_data` steady until it sees `mem_ready`. Neither ready signal depends combinationally on the other side.

Top module: `store_buffer`

## Requirements
- R1: After reset every slot is free, so `alloc_ready` is 1 and `mem_valid` is 0.
- R2: A store is taken on a rising edge where `alloc_valid` and `alloc_ready` are both 1. `alloc_ready` is 0 exactly while all ENTRIES slots are occupied. It does not rise in the same cycle as a memory accept.
- R3: A tag value of 0 means the value field beside it is valid. A non-zero tag means the operand is still outstanding, and it is delivered later by a broadcast carrying that same tag.
- R4: When `res_valid` is 1 and `res_tag` equals the non-zero tag a slot is waiting on for its base or its data, the slot captures `res_value` for that operand. One broadcast can satisfy the base and the data of any number of slots at once.
- R5: A broadcast in the same cycle as an allocation whose base tag or data tag matches `res_tag` (non-zero) is captured by the new slot.
- R6: The effective address is the base value plus the OFF_W-bit offset sign-extended to WORD_W, modulo 2^WORD_W.
- R7: The address is formed on the first edge at which the slot already holds its base. A store allocated at edge k with both tags 0 presents `mem_valid` after edge k+1.
- R8: Only the oldest occupied slot may drive the memory port. `mem_valid` is 1 only while that slot holds both its address and its data, and it stays 0 while no slot is occupied.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, the next cycle keeps `mem_valid` high with unchanged `mem_addr` and `mem_data`.
- R10: The slot of a store accepted by memory (`mem_valid` and `mem_ready`) is freed at that edge. If the buffer was full, `alloc_ready` is 1 in the following cycle.
- R11: A broadcast with tag 0, or with a tag no slot is waiting on, changes no stored operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue stage offers a store |
| alloc_ready | output | 1 | A free slot exists |
| alloc_base_tag | input | TAG_W | Producer tag of the base, 0 when the value is valid |
| alloc_base_val | input | WORD_W | Base value when its tag is 0 |
| alloc_offset | input | OFF_W | Signed immediate offset |
| alloc_data_tag | input | TAG_W | Producer tag of the store data, 0 when the value is valid |
| alloc_data_val | input | WORD_W | Store data when its tag is 0 |
| res_valid | input | 1 | Result broadcast present this cycle |
| res_tag | input | TAG_W | Tag of the broadcast result |
| res_value | input | WORD_W | Broadcast result value |
| mem_valid | output | 1 | Oldest store is ready to write |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| mem_addr | output | WORD_W | Write address of the oldest store |
| mem_data | output | WORD_W | Write data of the oldest store |

## Verification
A slot that misses a tag match, or that captures a value it should ignore, shows up in one of two ways: `mem_valid` never rises for that store and the buffer fills until `alloc_ready` stays low, or the write leaves memory with a wrong `mem_data` or `mem_addr`. Either symptom appears within a few cycles of the store reaching the head. Broken head or tail pointers reorder writes, or change when `alloc_ready` falls, relative to the number of outstanding stores. Because the reference model is compared every cycle, any such fault is reported in the cycle it first reaches the ports.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY     = 2'd0,
    SLOT_GATHER    = 2'd1,
    SLOT_ADDRESSED = 2'd2
  } slot_phase_e;
endpackage

// File: rtl/sb_operand.sv
// One tagged operand: a value plus the tag of its producer (0 = value present).
module sb_operand #(
  parameter int WORD_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [WORD_W-1:0] in_val,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [WORD_W-1:0] bus_value,
  output logic              ready,
  output logic [WORD_W-1:0] value
);
  logic [TAG_W-1:0]  tag_q;
  logic [WORD_W-1:0] val_q;
  logic              in_hit, wait_hit;

  // same-cycle bypass for the allocating store (R5)
  assign in_hit   = bus_valid && (in_tag != '0) && (bus_tag == in_tag);
  // capture for an operand already waiting (R4, R11)
  assign wait_hit = bus_valid && (tag_q != '0) && (bus_tag == tag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      val_q <= '0;
    end else if (load_en) begin
      if (in_hit) begin
        tag_q <= '0;
        val_q <= bus_value;
      end else begin
        tag_q <= in_tag;
        val_q <= in_val;
      end
    end else if (wait_hit) begin
      tag_q <= '0;
      val_q <= bus_value;
    end
  end

  assign ready = (tag_q == '0);
  assign value = val_q;
endmodule

// File: rtl/sb_slot.sv
// One store slot: base operand, offset, computed address and data operand.
module sb_slot
  import sb_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int TAG_W  = 4,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              release_en,
  input  logic [TAG_W-1:0]  in_base_tag,
  input  logic [WORD_W-1:0] in_base_val,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic [TAG_W-1:0]  in_data_tag,
  input  logic [WORD_W-1:0] in_data_val,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [WORD_W-1:0] bus_value,
  output logic              occupied,
  output logic              addr_ok,
  output logic              data_ok,
  output logic [WORD_W-1:0] addr_out,
  output logic [WORD_W-1:0] data_out
);
  localparam int EXT_W = WORD_W - OFF_W;

  slot_phase_e       phase_q;
  logic [OFF_W-1:0]  off_q;
  logic [WORD_W-1:0] addr_q;
  logic              base_rdy;
  logic [WORD_W-1:0] base_val;
  logic [WORD_W-1:0] off_ext;

  sb_operand #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .in_tag(in_base_tag), .in_val(in_base_val),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
    .ready(base_rdy), .value(base_val)
  );

  sb_operand #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_data (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .in_tag(in_data_tag), .in_val(in_data_val),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
    .ready(data_ok), .value(data_out)
  );

  assign off_ext = {{EXT_W{off_q[OFF_W-1]}}, off_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= SLOT_EMPTY;
      off_q   <= '0;
      addr_q  <= '0;
    end else if (load_en) begin
      phase_q <= SLOT_GATHER;
      off_q   <= in_offset;
    end else if (release_en) begin
      phase_q <= SLOT_EMPTY;
    end else if (phase_q == SLOT_GATHER && base_rdy) begin
      addr_q  <= base_val + off_ext;
      phase_q <= SLOT_ADDRESSED;
    end
  end

  assign occupied = (phase_q != SLOT_EMPTY);
  assign addr_ok  = (phase_q == SLOT_ADDRESSED);
  assign addr_out = addr_q;
endmodule

// File: rtl/sb_ring.sv
// Allocation-order bookkeeping: tail for new stores, head for the oldest.
module sb_ring #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full
);
  logic [CNT_W-1:0] count_q;

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_idx <= '0;
      tail_idx <= '0;
      count_q  <= '0;
    end else begin
      if (push) tail_idx <= next_idx(tail_idx);
      if (pop)  head_idx <= next_idx(head_idx);
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign full = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int ENTRIES = 4,
  parameter int WORD_W  = 32,
  parameter int TAG_W   = 4,
  parameter int OFF_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [TAG_W-1:0]  alloc_base_tag,
  input  logic [WORD_W-1:0] alloc_base_val,
  input  logic [OFF_W-1:0]  alloc_offset,
  input  logic [TAG_W-1:0]  alloc_data_tag,
  input  logic [WORD_W-1:0] alloc_data_val,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [WORD_W-1:0] res_value,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic              push, pop, full;
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic [ENTRIES-1:0] load_vec, release_vec, occ_vec, aok_vec, dok_vec;
  logic [WORD_W-1:0] slot_addr [ENTRIES];
  logic [WORD_W-1:0] slot_data [ENTRIES];

  assign alloc_ready = !full;
  assign push        = alloc_valid && alloc_ready;
  assign pop         = mem_valid && mem_ready;

  sb_ring #(.DEPTH(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign load_vec[i]    = push && (tail_idx == IDX_W'(i));
    assign release_vec[i] = pop  && (head_idx == IDX_W'(i));

    sb_slot #(.WORD_W(WORD_W), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_vec[i]), .release_en(release_vec[i]),
      .in_base_tag(alloc_base_tag), .in_base_val(alloc_base_val),
      .in_offset(alloc_offset),
      .in_data_tag(alloc_data_tag), .in_data_val(alloc_data_val),
      .bus_valid(res_valid), .bus_tag(res_tag), .bus_value(res_value),
      .occupied(occ_vec[i]), .addr_ok(aok_vec[i]), .data_ok(dok_vec[i]),
      .addr_out(slot_addr[i]), .data_out(slot_data[i])
    );
  end

  // only the oldest slot may write (R8)
  assign mem_valid = occ_vec[head_idx] & aok_vec[head_idx] & dok_vec[head_idx];
  assign mem_addr  = slot_addr[head_idx];
  assign mem_data  = slot_data[head_idx];
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int ENTRIES = 4,
  parameter int WORD_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_data
);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [CNT_W-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + CNT_W'(alloc_valid && alloc_ready) - CNT_W'(mem_valid && mem_ready);
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R9

  AST_READY_TRACKS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready == (occ != CNT_W'(ENTRIES))); // R2

  AST_NO_WRITE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !mem_valid); // R8

  AST_FREE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ready && mem_valid && mem_ready |=> alloc_ready); // R10
endmodule

bind store_buffer sb_checker #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_sb_checker (
  .clk(clk), .rst_n(rst_n),
  .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data)
);

// File: tb/store_buffer_bench.sv
`timescale 1ns/1ps
module store_buffer_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [3:0]  alloc_base_tag = '0;
  logic [31:0] alloc_base_val = '0;
  logic [11:0] alloc_offset = '0;
  logic [3:0]  alloc_data_tag = '0;
  logic [31:0] alloc_data_val = '0;
  logic        res_valid = 1'b0;
  logic [3:0]  res_tag = '0;
  logic [31:0] res_value = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_data;

  store_buffer u_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_base_tag(alloc_base_tag), .alloc_base_val(alloc_base_val),
    .alloc_offset(alloc_offset),
    .alloc_data_tag(alloc_data_tag), .alloc_data_val(alloc_data_val),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [3:0]  btag;
    logic [31:0] base;
    logic [11:0] off;
    bit          adone;
    logic [31:0] addr;
    logic [3:0]  dtag;
    logic [31:0] data;
  } store_t;

  store_t mq[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  function automatic bit exp_valid();
    return (mq.size() > 0) && mq[0].adone && (mq[0].dtag == 4'd0);
  endfunction

  task automatic check_bit(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", cur_req, what, act, exp);
    end
  endtask

  task automatic check_word(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    check_bit("alloc_ready", alloc_ready, mq.size() < N);
    check_bit("mem_valid", mem_valid, exp_valid());
    if (exp_valid()) begin
      check_word("mem_addr", mem_addr, mq[0].addr);
      check_word("mem_data", mem_data, mq[0].data);
    end
  endtask

  task automatic model_tick();
    bit fire_m, fire_a;
    store_t s;
    fire_m = exp_valid() && mem_ready;
    fire_a = alloc_valid && (mq.size() < N);
    foreach (mq[k]) begin
      if (!mq[k].adone && mq[k].btag == 4'd0) begin
        mq[k].addr  = mq[k].base + {{20{mq[k].off[11]}}, mq[k].off};
        mq[k].adone = 1'b1;
      end else if (res_valid && mq[k].btag != 4'd0 && res_tag == mq[k].btag) begin
        mq[k].base = res_value;
        mq[k].btag = 4'd0;
      end
      if (res_valid && mq[k].dtag != 4'd0 && res_tag == mq[k].dtag) begin
        mq[k].data = res_value;
        mq[k].dtag = 4'd0;
      end
    end
    if (fire_m) void'(mq.pop_front());
    if (fire_a) begin
      s.btag = alloc_base_tag; s.base = alloc_base_val; s.off = alloc_offset;
      s.adone = 1'b0; s.addr = '0;
      s.dtag = alloc_data_tag; s.data = alloc_data_val;
      if (res_valid && s.btag != 4'd0 && res_tag == s.btag) begin s.base = res_value; s.btag = 4'd0; end
      if (res_valid && s.dtag != 4'd0 && res_tag == s.dtag) begin s.data = res_value; s.dtag = 4'd0; end
      mq.push_back(s);
    end
  endtask

  task automatic step(input bit av, input logic [3:0] bt, input logic [31:0] bv,
                      input logic [11:0] of, input logic [3:0] dt, input logic [31:0] dv,
                      input bit cv, input logic [3:0] ct, input logic [31:0] cval, input bit mr);
    @(negedge clk);
    compare();
    alloc_valid = av; alloc_base_tag = bt; alloc_base_val = bv; alloc_offset = of;
    alloc_data_tag = dt; alloc_data_val = dv;
    res_valid = cv; res_tag = ct; res_value = cval; mem_ready = mr;
    @(posedge clk);
    model_tick();
  endtask

  task automatic idle(input int n, input bit mr);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, mr);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle state straight after reset
    cur_req = "R1";
    check_bit("alloc_ready", alloc_ready, 1'b1);
    check_bit("mem_valid", mem_valid, 1'b0);
    idle(1, 1);

    // R6 / R7: ready operands, negative and positive offsets
    cur_req = "R6";
    step(1, 0, 32'h0000_1000, 12'hFFC, 0, 32'hAAAA_0001, 0, 0, 0, 1);
    step(1, 0, 32'hFFFF_FFF0, 12'h7FF, 0, 32'h0000_0002, 0, 0, 0, 1);
    cur_req = "R7";
    idle(6, 1);

    // R3 then R4: base and data arrive later by broadcast
    cur_req = "R3";
    step(1, 4'd5, 0, 12'h010, 4'd6, 0, 0, 0, 0, 1);
    idle(3, 1);
    cur_req = "R4";
    step(0, 0, 0, 0, 0, 0, 1, 4'd5, 32'h0000_2000, 1);
    idle(2, 1);
    step(0, 0, 0, 0, 0, 0, 1, 4'd6, 32'hDEAD_BEEF, 1);
    idle(3, 1);

    // R5: bypass of a broadcast coinciding with the allocation
    cur_req = "R5";
    step(1, 4'd7, 0, 12'h004, 4'd7, 0, 1, 4'd7, 32'h0000_3000, 1);
    idle(4, 1);

    // R11: tag-0 and unmatched broadcasts leave a waiting store alone
    cur_req = "R11";
    step(1, 0, 32'h0000_0040, 12'h000, 4'd9, 32'h1111_1111, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 4'd0, 32'h5555_5555, 1);
    step(0, 0, 0, 0, 0, 0, 1, 4'd3, 32'h6666_6666, 1);
    idle(2, 1);
    cur_req = "R4";
    step(0, 0, 0, 0, 0, 0, 1, 4'd9, 32'h7777_0009, 1);
    idle(3, 1);

    // R8: a ready younger store waits behind a stalled older one
    cur_req = "R8";
    step(1, 0, 32'h0000_0100, 12'h001, 4'd2, 0, 0, 0, 0, 1);
    step(1, 0, 32'h0000_0200, 12'h002, 0, 32'hBBBB_0002, 0, 0, 0, 1);
    idle(5, 1);
    step(0, 0, 0, 0, 0, 0, 1, 4'd2, 32'hAAAA_0002, 1);
    idle(6, 1);

    // R2 / R9 / R10: fill while memory stalls, then drain
    cur_req = "R2";
    for (int i = 0; i < 6; i++)
      step(1, 0, 32'h0001_0000 + i, 12'(i), 0, 32'hC000_0000 + i, 0, 0, 0, 0);
    cur_req = "R9";
    idle(3, 0);
    cur_req = "R10";
    idle(8, 1);

    // mixed random traffic
    cur_req = "R7";
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), 4'($urandom_range(0, 5)), $urandom, 12'($urandom),
           4'($urandom_range(0, 5)), $urandom, $urandom_range(0, 1),
           4'($urandom_range(0, 5)), $urandom, $urandom_range(0, 3) != 0);
    idle(20, 1);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule